// File: doc/BRIEF.md
# Radio Transmit Sequencer

This block is the control state machine that steps a packet radio through one transmission. It starts from a ready state in which the frequency synthesizer is locked. A transmission starts on a rising edge of a trigger pin or on a start command. The block first spends a fixed warm-up time with the synthesizer steered to the transmit channel and the power amplifier switched on. It then emits a generated synchronization header: four zero preamble bytes followed by the start-of-frame byte 0xA7. After the header it sends a length byte and the payload, both read from the frame buffer, each byte held for a fixed number of microseconds.

When the last byte has been sent, the block raises an end-of-frame interrupt pulse and switches the amplifier and transmit channel off. It then returns to the ready state. If a receive request arrived while the transmission was running, it instead waits a settling time and enters the listening state. All delays count a one-microsecond tick input. The byte stream goes to a modulator as a data byte plus a one-cycle strobe. The frame buffer is read through a combinational address/data port.

Top module: `txseq_top`

## Requirements
- R1: After reset the state code is 0 (off), and pa_en, pll_tx_sel, sym_stb and irq_end are all low. Command code 3 (idle) moves state 0 to 1 (ready) and state 5 (listening) to 1. Command code 2 (receive) moves state 1 to 5.
- R2: In state 1 with pll_lock high, a rising edge on trig_pin or command code 1 (go) moves the block to state 2 (warm-up) on the next clock, with pa_en and pll_tx_sel high.
- R3: State 2 lasts exactly WARM_US (16) ticks of us_tick. The block then enters state 3 (busy).
- R4: The first five strobed bytes are 0x00, 0x00, 0x00, 0x00, 0xA7. The first sym_stb pulse appears in the cycle the block enters state 3.
- R5: After the header come the byte at buffer address 0 (the length, 1 to 127, in bits 6:0) and the bytes at addresses 1 to length. Every byte is marked by one sym_stb pulse, and consecutive pulses are BYTE_US (32) ticks apart.
- R6: irq_end pulses for one cycle, once per frame, BYTE_US ticks after the last byte's strobe. In that cycle the block has left state 3, and pa_en and pll_tx_sel are low.
- R7: With no receive request pending at frame end, the block returns to state 1.
- R8: A receive command in state 2 or 3 leaves the transmission unchanged. After the frame ends, the block holds state 4 (settling) for SETTLE_US (32) ticks and then enters state 5.
- R9: A trigger edge or go command in any state other than 1 is ignored. The state is unchanged, pa_en stays as it was, and a frame in progress keeps its bytes and timing.
- R10: A trigger edge and a go command in the same cycle start exactly one frame.
- R11: In state 1 with pll_lock low, trigger edges and go commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_pin | input | 1 | Transmit trigger; acts on its rising edge |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 2 | 1 go, 2 receive, 3 idle |
| pll_lock | input | 1 | Synthesizer lock status |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| fb_addr | output | 7 | Frame buffer read address |
| fb_data | input | 8 | Frame buffer read data for fb_addr, same cycle |
| pa_en | output | 1 | Power amplifier enable |
| pll_tx_sel | output | 1 | 1 selects transmit frequency, 0 receive |
| sym_stb | output | 1 | New byte on sym_data |
| sym_data | output | 8 | Byte to the modulator |
| state_o | output | 3 | State code 0 to 5 |
| irq_end | output | 1 | End-of-frame interrupt pulse |

## Verification
The assertions assume that us_tick is a single-cycle pulse, that commands last one cycle, and that the length byte in the buffer lies between 1 and 127. The bench raises the tick every second clock and holds each command for exactly one cycle. It loads only legal lengths: 1, 3 and 127. It moves trig_pin and the command port half a cycle away from the sampling edge, so an edge and a command can be placed in the same cycle on purpose.

// File: rtl/txseq_pkg.sv
package txseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_READY  = 3'd1,
    ST_WARM   = 3'd2,
    ST_BUSY   = 3'd3,
    ST_SETTLE = 3'd4,
    ST_RXON   = 3'd5
  } txs_state_e;

  localparam logic [1:0] CMD_GO   = 2'd1;
  localparam logic [1:0] CMD_RX   = 2'd2;
  localparam logic [1:0] CMD_IDLE = 2'd3;
endpackage

// File: rtl/txseq_tmr.sv
module txseq_tmr #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          done
);
  logic [TW-1:0] cnt_q, cnt_d;

  assign done = run && tick && (cnt_q == limit - TW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || clr)  cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the interval counter never passes its limit
  a_r3_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));
endmodule

// File: rtl/txseq_bytesrc.sv
module txseq_bytesrc #(
  parameter int         PRE_LEN = 4,
  parameter logic [7:0] SFD     = 8'hA7,
  parameter int         IW      = 8,
  parameter int         AW      = 7
) (
  input  logic [IW-1:0] idx,
  input  logic [7:0]    fb_data,
  output logic [7:0]    byte_o,
  output logic [AW-1:0] fb_addr
);
  localparam logic [IW-1:0] SFD_IDX = IW'(PRE_LEN);
  localparam logic [IW-1:0] BUF_IDX = IW'(PRE_LEN + 1);

  logic [IW-1:0] buf_off;
  assign buf_off = idx - BUF_IDX;

  always_comb begin
    fb_addr = '0;
    if (idx < SFD_IDX)       byte_o = 8'h00;
    else if (idx == SFD_IDX) byte_o = SFD;
    else begin
      byte_o  = fb_data;
      fb_addr = AW'(buf_off);
    end
  end
endmodule

// File: rtl/txseq_trig.sv
module txseq_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic cmd_go,
  input  logic armed,
  output logic go
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin;
  end

  assign go = armed && ((pin && !pin_q) || cmd_go);
endmodule

// File: rtl/txseq_top.sv
module txseq_top #(
  parameter int         WARM_US   = 16,
  parameter int         BYTE_US   = 32,
  parameter int         SETTLE_US = 32,
  parameter int         PRE_LEN   = 4,
  parameter logic [7:0] SFD       = 8'hA7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_pin,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  input  logic       pll_lock,
  input  logic       us_tick,
  output logic [6:0] fb_addr,
  input  logic [7:0] fb_data,
  output logic       pa_en,
  output logic       pll_tx_sel,
  output logic       sym_stb,
  output logic [7:0] sym_data,
  output logic [2:0] state_o,
  output logic       irq_end
);
  import txseq_pkg::*;

  localparam int LW   = 7;
  localparam int MAX1 = (WARM_US > BYTE_US) ? WARM_US : BYTE_US;
  localparam int MAXT = (MAX1 > SETTLE_US) ? MAX1 : SETTLE_US;
  localparam int TW   = $clog2(MAXT + 1);
  localparam int IW   = $clog2(PRE_LEN + 2 + (1 << LW));

  logic [1:0]    rst_ff;
  logic          rst_sn;
  txs_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, nxt_idx;
  logic [LW-1:0] len_q;
  logic          rx_pend_q, go, load, frame_done, run, tmr_clr, tmr_done, last_byte;
  logic [TW-1:0] limit;
  logic [7:0]    src_byte;
  logic          cmd_go, cmd_rx, cmd_idle;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sn = rst_ff[1];

  assign cmd_go   = cmd_valid && (cmd_code == CMD_GO);
  assign cmd_rx   = cmd_valid && (cmd_code == CMD_RX);
  assign cmd_idle = cmd_valid && (cmd_code == CMD_IDLE);

  txseq_trig u_trig (
    .clk(clk), .rst_n(rst_sn), .pin(trig_pin), .cmd_go(cmd_go),
    .armed((state_q == ST_READY) && pll_lock), .go(go)
  );

  txseq_tmr #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_sn), .run(run), .clr(tmr_clr),
    .tick(us_tick), .limit(limit), .done(tmr_done)
  );

  assign nxt_idx   = (state_q == ST_WARM) ? '0 : idx_q + IW'(1);
  assign last_byte = (idx_q == IW'(PRE_LEN + 1) + IW'(len_q));

  txseq_bytesrc #(.PRE_LEN(PRE_LEN), .SFD(SFD), .IW(IW), .AW(LW)) u_src (
    .idx(nxt_idx), .fb_data(fb_data), .byte_o(src_byte), .fb_addr(fb_addr)
  );

  always_comb begin
    state_d    = state_q;
    load       = 1'b0;
    frame_done = 1'b0;
    run        = 1'b0;
    limit      = TW'(BYTE_US);
    case (state_q)
      ST_OFF:   if (cmd_idle) state_d = ST_READY;
      ST_READY: begin
        if (go)          state_d = ST_WARM;
        else if (cmd_rx) state_d = ST_RXON;
      end
      ST_WARM: begin
        run   = 1'b1;
        limit = TW'(WARM_US);
        if (tmr_done) begin
          state_d = ST_BUSY;
          load    = 1'b1;
        end
      end
      ST_BUSY: begin
        run = 1'b1;
        if (tmr_done) begin
          if (last_byte) begin
            frame_done = 1'b1;
            state_d    = (rx_pend_q || cmd_rx) ? ST_SETTLE : ST_READY;
          end else begin
            load = 1'b1;
          end
        end
      end
      ST_SETTLE: begin
        run   = 1'b1;
        limit = TW'(SETTLE_US);
        if (tmr_done) state_d = ST_RXON;
      end
      ST_RXON:  if (cmd_idle) state_d = ST_READY;
      default:  state_d = ST_OFF;
    endcase
  end

  assign tmr_clr = load || (state_d != state_q);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q   <= ST_OFF;
      idx_q     <= '0;
      len_q     <= '0;
      rx_pend_q <= 1'b0;
      sym_stb   <= 1'b0;
      sym_data  <= '0;
      irq_end   <= 1'b0;
    end else begin
      state_q <= state_d;
      sym_stb <= load;
      irq_end <= frame_done;
      if (load) begin
        idx_q    <= nxt_idx;
        sym_data <= src_byte;
        if (nxt_idx == IW'(PRE_LEN + 1)) len_q <= fb_data[LW-1:0];
      end
      if (go)
        rx_pend_q <= 1'b0;
      else if (cmd_rx && (state_q == ST_WARM || state_q == ST_BUSY))
        rx_pend_q <= 1'b1;
      else if (state_q == ST_SETTLE && tmr_done)
        rx_pend_q <= 1'b0;
    end
  end

  assign state_o    = state_q;
  assign pa_en      = (state_q == ST_WARM) || (state_q == ST_BUSY);
  assign pll_tx_sel = (state_q == ST_WARM) || (state_q == ST_BUSY);

  // R9: warm-up is reachable only from the ready state
  a_r9_warm_only_from_ready: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q != ST_READY && state_q != ST_WARM) |=> (state_q != ST_WARM));
  // R11: no start while the synthesizer is unlocked
  a_r11_no_start_unlocked: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_READY && !pll_lock) |=> (state_q != ST_WARM));
  // R4: bytes are strobed only while busy
  a_r4_stb_in_busy: assert property (@(posedge clk) disable iff (!rst_sn)
    sym_stb |-> (state_q == ST_BUSY));
  // R6: end interrupt lasts one cycle
  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_end |=> !irq_end);
  // R6: end interrupt coincides with leaving busy
  a_r6_irq_leaves_busy: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_end |-> ((state_q == ST_READY || state_q == ST_SETTLE) && $past(state_q) == ST_BUSY));
  // R8: a pending receive request leads through settling
  a_r8_pend_to_settle: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_BUSY && rx_pend_q) |=> (state_q == ST_BUSY || state_q == ST_SETTLE));
endmodule

// File: tb/txseq_top_tb.sv
module txseq_top_tb;
  localparam int CLK_HALF = 5;
  localparam int WD_CYC   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_pin = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_code = 2'd0;
  logic       pll_lock = 1'b1;
  logic       us_tick = 1'b0;
  logic [6:0] fb_addr;
  logic [7:0] fb_data;
  logic       pa_en, pll_tx_sel, sym_stb, irq_end;
  logic [7:0] sym_data;
  logic [2:0] state_o;

  logic [7:0] mem [128];
  int tick_total = 0;
  int tick_div = 0;
  int nrec = 0;
  int irq_cnt = 0;
  int irq_t = 0;
  int rec_t [140];
  logic [7:0] rec_b [140];
  int checks = 0;
  int errors = 0;

  assign fb_data = mem[fb_addr];

  txseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .pll_lock(pll_lock), .us_tick(us_tick),
    .fb_addr(fb_addr), .fb_data(fb_data), .pa_en(pa_en), .pll_tx_sel(pll_tx_sel),
    .sym_stb(sym_stb), .sym_data(sym_data), .state_o(state_o), .irq_end(irq_end)
  );

  always #CLK_HALF clk = ~clk;

  always @(negedge clk) begin
    tick_div = (tick_div + 1) % 2;
    us_tick  = (tick_div == 1);
  end

  always @(posedge clk) if (us_tick) tick_total <= tick_total + 1;

  always @(negedge clk) begin
    if (sym_stb && nrec < 140) begin
      rec_b[nrec] = sym_data;
      rec_t[nrec] = tick_total;
      nrec = nrec + 1;
    end
    if (irq_end) begin
      irq_cnt = irq_cnt + 1;
      irq_t   = tick_total;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  task automatic send_cmd(input logic [1:0] code);
    cmd_valid = 1'b1;
    cmd_code  = code;
    step;
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) step;
    rst_n = 1'b1;
    repeat (4) step;
    chk(state_o == 3'd0, "R1 reset state", state_o, 0);
    chk(!pa_en && !pll_tx_sel && !sym_stb && !irq_end, "R1 reset outputs",
        {pa_en, pll_tx_sel, sym_stb, irq_end}, 0);
  endtask

  task automatic t_ignore(input int st, input string tag);
    logic pa0;
    pa0 = pa_en;
    trig_pin = 1'b1;
    send_cmd(2'd1);
    step;
    trig_pin = 1'b0;
    step;
    chk(state_o == 3'(st), tag, state_o, st);
    chk(pa_en == pa0 && !pa_en, tag, pa_en, 0);
  endtask

  task automatic t_modes;
    send_cmd(2'd3);
    chk(state_o == 3'd1, "R1 idle from off", state_o, 1);
    send_cmd(2'd2);
    chk(state_o == 3'd5, "R1 receive from ready", state_o, 5);
    send_cmd(2'd3);
    chk(state_o == 3'd1, "R1 idle from listening", state_o, 1);
  endtask

  task automatic t_nolock;
    pll_lock = 1'b0;
    t_ignore(1, "R11 start ignored while unlocked");
    pll_lock = 1'b1;
  endtask

  task automatic run_frame(input int len, input bit by_pin, input bit by_cmd,
                           input bit rx_mid, input bit poke);
    int t0, tend, bad_h, bad_p, bad_s;
    for (int i = 1; i <= len; i++) mem[i] = 8'((i * 29 + len * 3) ^ 8'h5A);
    mem[0] = 8'(len);
    nrec = 0;
    irq_cnt = 0;
    trig_pin = by_pin;
    if (by_cmd) begin
      cmd_valid = 1'b1;
      cmd_code  = 2'd1;
    end
    step;
    cmd_valid = 1'b0;
    chk(state_o == 3'd2, "R2 warm-up entered", state_o, 2);
    chk(pa_en && pll_tx_sel, "R2 amplifier and transmit channel", {pa_en, pll_tx_sel}, 3);
    t0 = tick_total;
    while (state_o == 3'd2) step;
    chk(state_o == 3'd3, "R3 busy after warm-up", state_o, 3);
    chk(tick_total - t0 == 16, "R3 warm-up ticks", tick_total - t0, 16);
    chk(nrec == 1, "R4 first strobe on busy entry", nrec, 1);
    trig_pin = 1'b0;
    if (rx_mid || poke) begin
      while (nrec < 7) step;
      if (poke) begin
        trig_pin = 1'b1;
        send_cmd(2'd1);
        step;
        trig_pin = 1'b0;
        step;
        chk(state_o == 3'd3, "R9 frame unaffected by trigger", state_o, 3);
      end
      if (rx_mid) begin
        send_cmd(2'd2);
        chk(state_o == 3'd3, "R8 receive request deferred", state_o, 3);
      end
    end
    while (irq_cnt == 0) step;
    tend = tick_total;
    chk(!pa_en && !pll_tx_sel, "R6 amplifier off at frame end", {pa_en, pll_tx_sel}, 0);
    if (rx_mid) chk(state_o == 3'd4, "R8 settling after frame", state_o, 4);
    else        chk(state_o == 3'd1, "R7 back to ready", state_o, 1);
    step;
    chk(!irq_end, "R6 one-cycle interrupt", irq_end, 0);
    chk(nrec == 6 + len, "R5 byte count", nrec, 6 + len);
    bad_h = 0;
    for (int i = 0; i < 4; i++) if (rec_b[i] != 8'h00) bad_h++;
    if (rec_b[4] != 8'hA7) bad_h++;
    chk(bad_h == 0, "R4 header bytes", bad_h, 0);
    bad_p = 0;
    for (int i = 0; i <= len; i++) if (rec_b[5 + i] != mem[i]) bad_p++;
    chk(bad_p == 0, "R5 length and payload bytes", bad_p, 0);
    bad_s = 0;
    for (int i = 1; i < nrec; i++) if (rec_t[i] - rec_t[i - 1] != 32) bad_s++;
    chk(bad_s == 0, "R5 byte spacing", bad_s, 0);
    chk(irq_t - rec_t[nrec - 1] == 32, "R6 interrupt timing", irq_t - rec_t[nrec - 1], 32);
    if (rx_mid) begin
      while (state_o == 3'd4) step;
      chk(state_o == 3'd5, "R8 listening after settle", state_o, 5);
      chk(tick_total - tend == 32, "R8 settle ticks", tick_total - tend, 32);
    end
    repeat (20) step;
    if (by_pin && by_cmd) chk(irq_cnt == 1, "R10 single frame from edge plus command", irq_cnt, 1);
    else                  chk(irq_cnt == 1, "R6 one interrupt per frame", irq_cnt, 1);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog: got %0d expected %0d", WD_CYC, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    t_reset;
    t_ignore(0, "R9 start ignored while off");
    t_modes;
    t_nolock;
    run_frame(3, 1'b1, 1'b0, 1'b0, 1'b0);
    run_frame(127, 1'b0, 1'b1, 1'b0, 1'b1);
    run_frame(1, 1'b1, 1'b1, 1'b1, 1'b0);
    t_ignore(5, "R9 start ignored while listening");
    send_cmd(2'd3);
    chk(state_o == 3'd1, "R1 idle after listening", state_o, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule